// File: doc/BRIEF.md
# Quad-Data-Rate Burst-Four Static Memory

This block is a synthesizable model of a separate-I/O static memory that moves four 18-bit words per access. Each access takes two cycles of the K clock, and data moves on both of its edges. All dual-edge timing is mapped onto a single internal clock `clk2x` that runs at twice the K rate. A phase bit alternates every `clk2x` edge. The slot that ends on a K-rise edge is flagged on the `kslot` output, and the slot that ends on a K#-rise edge is the one between two K-rise edges.

The read-select and write-select strobes are sampled only on K-rise edges. They share one address bus. A write accepted at edge E takes its four words from `d` on edges E+2, E+3, E+4 and E+5. Two active-low byte strobes, sampled with each word, mask the two halves of that word. A read accepted at edge E drives four words on `q` after edges E+RD_LAT through E+RD_LAT+3, and raises `q_oe` while it does. The burst address wraps inside an aligned group of four words.

A request of the same kind on the next K edge is dropped, because the previous burst still occupies the port. A read returns the array contents as they stood at its own sampling edge, so write words that land at or after that edge do not show up in it. The array is not cleared by reset.

Top module: `qdr4_sram`

## Requirements
- R1: While reset is asserted and right after it, `q_oe` is 0, `q` is 0 and `kslot` is 1.
- R2: `kslot` inverts on every `clk2x` edge while out of reset. It is 1 during the cycle before a K-rise edge. The first edge after reset is a K-rise edge.
- R3: `rd_n` and `wr_n` are sampled only on K-rise edges. A low level during a K#-rise slot starts nothing.
- R4: A write accepted at edge E with base address A stores the `d` values sampled on edges E+2, E+3, E+4 and E+5 at word offsets 0, 1, 2 and 3. The word for offset i is at address {A[AW-1:2], (A[1:0]+i) mod 4}.
- R5: For each word of a write burst, `bw_n[0]` low writes bits 8:0 and `bw_n[1]` low writes bits 17:9. With both strobes high the word is left unchanged. The strobes may differ from word to word.
- R6: A read accepted at edge E with base A puts word offset i (same wrapped address as R4) on `q`, with `q_oe` high, in the cycle after edge E+RD_LAT+i, for i = 0 to 3.
- R7: A read request is ignored if a read was accepted at the previous K-rise edge (two `clk2x` edges earlier). The same holds for a write request after an accepted write.
- R8: A read returns the array as it was before its own sampling edge. Write words stored on that edge or later are not visible to it.
- R9: Whenever no read word is being driven, `q_oe` is 0 and `q` is 0. The value 0 stands in for a high-impedance bus.
- R10: A read and a write requested on the same K-rise edge are both accepted, and both use the shared address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Internal clock at twice the K rate |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_n | input | 1 | Read-select strobe, active low |
| wr_n | input | 1 | Write-select strobe, active low |
| addr | input | AW | Burst base address |
| d | input | 18 | Write data word |
| bw_n | input | 2 | Byte-write strobes, active low (bit 0 covers 8:0, bit 1 covers 17:9) |
| kslot | output | 1 | High during a slot that ends on a K-rise edge |
| q | output | 18 | Read data word |
| q_oe | output | 1 | High while `q` carries read data |

## Verification
Reads and writes share one address bus and have separate data paths, so a read snapshot and a write word commit can fall on the same edge. The bench provokes this in three ways: it requests both on one K edge to the same address, it reads an address whose write burst is still arriving, and it runs a long random mix of commands and byte strobes. A behavioural model in the bench takes each read's snapshot before it applies that edge's write word. It then compares `q`, `q_oe` and `kslot` after every edge, so a read that shows a same-edge or later write word is reported.

// File: rtl/qdr4_sram.sv
module qdr4_sram #(
  parameter int AW     = 6,
  parameter int RD_LAT = 3
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [17:0]   d,
  input  logic [1:0]    bw_n,
  output logic          kslot,
  output logic [17:0]   q,
  output logic          q_oe
);
  localparam int DEPTH = 1 << AW;
  localparam int RSW   = (RD_LAT > 2) ? RD_LAT : 2;

  logic [17:0]    mem [DEPTH];
  logic [17:0]    snap [4];
  logic [17:0]    obuf [4];
  logic           ph;
  logic [4:0]     wsh;
  logic [RSW-1:0] rsh;
  logic [AW-1:0]  wa_cur, wbase, wrow, wptr;
  logic [1:0]     wcol, oidx;
  logic [2:0]     oleft;
  logic           rd_go, wr_go, rd_start, wr_en;

  function automatic logic [AW-1:0] wrap(input logic [AW-1:0] b, input logic [1:0] o);
    return {b[AW-1:2], 2'(b[1:0] + o)};
  endfunction

  assign kslot    = ~ph;
  assign rd_go    = ~ph & ~rd_n & ~rsh[1];
  assign wr_go    = ~ph & ~wr_n & ~wsh[1];
  assign rd_start = rsh[RD_LAT-1];
  assign wr_en    = |wsh[4:1];
  assign wcol     = wsh[1] ? 2'd0 : wsh[2] ? 2'd1 : wsh[3] ? 2'd2 : 2'd3;
  assign wrow     = wsh[1] ? wa_cur : wbase;
  assign wptr     = wrap(wrow, wcol);

  always_ff @(posedge clk2x) begin
    if (!rst_n) begin
      ph     <= 1'b0;
      wsh    <= '0;
      rsh    <= '0;
      wa_cur <= '0;
      wbase  <= '0;
      q      <= '0;
      q_oe   <= 1'b0;
      oidx   <= '0;
      oleft  <= '0;
    end else begin
      ph  <= ~ph;
      wsh <= {wsh[3:0], wr_go};
      rsh <= {rsh[RSW-2:0], rd_go};
      if (wr_go)  wa_cur <= addr;
      if (wsh[1]) wbase  <= wa_cur;
      if (rd_start) begin
        q     <= snap[0];
        q_oe  <= 1'b1;
        oidx  <= 2'd1;
        oleft <= 3'd3;
      end else if (oleft != 3'd0) begin
        q     <= obuf[oidx];
        oidx  <= oidx + 2'd1;
        oleft <= oleft - 3'd1;
      end else begin
        q    <= '0;
        q_oe <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk2x) begin
    if (rd_go)
      for (int i = 0; i < 4; i++) snap[i] <= mem[wrap(addr, 2'(i))];
    if (rd_start)
      for (int i = 0; i < 4; i++) obuf[i] <= snap[i];
    if (wr_en) begin
      if (!bw_n[0]) mem[wptr][8:0]  <= d[8:0];
      if (!bw_n[1]) mem[wptr][17:9] <= d[17:9];
    end
  end
endmodule

// File: rtl/qdr4_sram_chk.sv
module qdr4_sram_chk (
  input logic        clk2x,
  input logic        rst_n,
  input logic        kslot,
  input logic [17:0] q,
  input logic        q_oe,
  input logic        rd_go,
  input logic        wr_go
);
  AST_KSLOT_ALT: assert property (@(posedge clk2x) disable iff (!rst_n)
    $past(rst_n) |-> kslot != $past(kslot)); // R2

  AST_IDLE_ZERO: assert property (@(posedge clk2x) disable iff (!rst_n)
    !q_oe |-> q == 18'd0); // R9

  AST_BURST_RUN: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(q_oe) |=> q_oe); // R6

  AST_RD_GAP: assert property (@(posedge clk2x) disable iff (!rst_n)
    (rd_go && $past(rst_n, 2)) |-> !$past(rd_go, 2)); // R7

  AST_WR_GAP: assert property (@(posedge clk2x) disable iff (!rst_n)
    (wr_go && $past(rst_n, 2)) |-> !$past(wr_go, 2)); // R7
endmodule

bind qdr4_sram qdr4_sram_chk u_chk (
  .clk2x(clk2x), .rst_n(rst_n), .kslot(kslot), .q(q), .q_oe(q_oe),
  .rd_go(rd_go), .wr_go(wr_go)
);

// File: tb/qdr4_sram_bench.sv
module qdr4_sram_bench;
  localparam int AW = 6;
  localparam int L  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [17:0] d = '0;
  logic [1:0] bw_n = 2'b11;
  logic kslot, q_oe;
  logic [17:0] q;

  int checks = 0, errors = 0, en = 0, last_rd = -100, last_wr = -100;
  logic [17:0] mm [64];
  logic [17:0] oq [int];
  int wq [int];
  logic eoe = 1'b0, ek = 1'b1;
  logic [17:0] eq = '0;
  string tag = "R1";
  bit done = 0;

  qdr4_sram #(.AW(AW), .RD_LAT(L)) u_qdr4_sram (
    .clk2x(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .d(d), .bw_n(bw_n), .kslot(kslot), .q(q), .q_oe(q_oe));

  always #5 clk = ~clk;

  function automatic int wrapm(int b, int o);
    return (b & ~3) | ((b + o) & 3);
  endfunction

  always @(posedge clk) if (rst_n) begin
    if (en % 2 == 0) begin
      if (!rd_n && last_rd != en - 2) begin
        for (int i = 0; i < 4; i++) oq[en + L + i] = mm[wrapm(int'(addr), i)];
        last_rd = en;
      end
      if (!wr_n && last_wr != en - 2) begin
        for (int i = 0; i < 4; i++) wq[en + 2 + i] = wrapm(int'(addr), i);
        last_wr = en;
      end
    end
    if (wq.exists(en)) begin
      if (!bw_n[0]) mm[wq[en]][8:0]  = d[8:0];
      if (!bw_n[1]) mm[wq[en]][17:9] = d[17:9];
      wq.delete(en);
    end
    eoe = oq.exists(en);
    eq  = eoe ? oq[en] : 18'd0;
    if (eoe) oq.delete(en);
    ek = ((en + 1) % 2 == 0);
    en++;
  end

  task automatic chk(string r, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at edge %0d", r, act, exp, en);
    end
  endtask

  task automatic cmp;
    chk("R2", 18'(kslot), 18'(ek));
    chk(eoe ? tag : "R9", 18'(q_oe), 18'(eoe));
    chk(eoe ? tag : "R9", q, eq);
  endtask

  task automatic step(bit r, bit w, int a, logic [1:0] bw);
    rd_n = r; wr_n = w; addr = AW'(a); bw_n = bw; d = 18'($urandom);
    @(negedge clk);
    cmp();
  endtask

  task automatic kpair(bit r, bit w, int a, logic [1:0] b0, logic [1:0] b1);
    step(r, w, a, b0);
    step(1, 1, a, b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", 18'(q_oe), 18'd0);
    chk("R1", q, 18'd0);
    chk("R1", 18'(kslot), 18'd1);
    rst_n = 1'b1;
    tag = "R4";
    for (int a = 0; a < 64; a += 4) begin
      kpair(1, 0, a, 2'b00, 2'b00);
      kpair(1, 1, 0, 2'b00, 2'b00);
    end
    repeat (4) kpair(1, 1, 0, 2'b00, 2'b00);
    tag = "R6";
    for (int a = 1; a < 40; a += 5) begin
      kpair(0, 1, a, 2'b11, 2'b11);
      kpair(1, 1, 0, 2'b11, 2'b11);
    end
    tag = "R4";
    kpair(1, 0, 6, 2'b00, 2'b00);
    kpair(1, 1, 0, 2'b00, 2'b00);
    repeat (2) kpair(1, 1, 0, 2'b11, 2'b11);
    kpair(0, 1, 4, 2'b11, 2'b11);
    repeat (4) kpair(1, 1, 0, 2'b11, 2'b11);
    tag = "R7";
    for (int i = 0; i < 8; i++) kpair(0, 1, 8 + i, 2'b11, 2'b11);
    for (int i = 0; i < 8; i++) kpair(1, 0, 12 + i, 2'b00, 2'b00);
    for (int i = 0; i < 8; i++) kpair(0, 1, 12 + i, 2'b11, 2'b11);
    tag = "R3";
    for (int i = 0; i < 4; i++) begin
      step(1, 1, 0, 2'b00);
      step(0, 0, 16 + 4 * i, 2'b00);
    end
    for (int i = 0; i < 4; i++) kpair(0, 1, 16 + 4 * i, 2'b11, 2'b11);
    tag = "R5";
    for (int i = 0; i < 6; i++) begin
      kpair(1, 0, 32 + 4 * i, 2'(i), 2'(i + 1));
      kpair(1, 1, 0, 2'(i + 2), 2'(i + 3));
    end
    for (int i = 0; i < 6; i++) kpair(0, 1, 32 + 4 * i, 2'b11, 2'b11);
    tag = "R10";
    kpair(0, 0, 20, 2'b00, 2'b00);
    kpair(1, 1, 0, 2'b00, 2'b00);
    kpair(0, 1, 20, 2'b11, 2'b11);
    tag = "R8";
    kpair(1, 0, 24, 2'b00, 2'b00);
    kpair(0, 1, 24, 2'b00, 2'b00);
    kpair(1, 1, 0, 2'b11, 2'b11);
    kpair(0, 1, 24, 2'b11, 2'b11);
    kpair(1, 1, 0, 2'b11, 2'b11);
    tag = "R6";
    for (int i = 0; i < 1500; i++)
      kpair(1'($urandom), 1'($urandom), int'($urandom % 64),
            2'($urandom), 2'($urandom));
    repeat (8) kpair(1, 1, 0, 2'b11, 2'b11);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule